// File: doc/BRIEF.md
# MII Receive 4B/5B Decoder with Delimiter Stripping

This block sits between a link receiver that delivers one 5-bit code group per clock and an Ethernet MAC that expects a nibble-wide receive interface. It turns each code group into a 4-bit nibble, a data-valid flag and an error flag. It also finds where each packet starts and ends.

A packet opens with the two-group delimiter J then K. The J group is absorbed. The K group is passed on as the first valid nibble, which marks the start of frame. Data groups follow, and a T group followed by an R group closes the packet. Neither of the closing groups reaches the MAC. A frame-lock input gates everything: while it is low the MAC sees nothing, and the block forgets any packet in progress.

Top module: `mii_rx_decoder`

## Requirements
- R1: Inside a packet, each data group is decoded to its nibble with rx_dv=1 and rx_er=0, one clock after the group is sampled. The mapping (group to nibble) is: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R2: While sync_ok is low, rx_dv and rx_er are low in that same cycle. A packet in progress is abandoned: after sync_ok returns, data groups are not forwarded until a new J K delimiter arrives.
- R3: When J (11000) is immediately followed by K (10001), the cycle after K is sampled shows rxd=0101, rx_dv=1 and rx_er=0.
- R4: The J group of a start delimiter never appears on the interface: rx_dv stays low in the cycle after J is sampled.
- R5: A J followed by anything other than K returns the block to idle with rx_dv low. Data groups after it are not forwarded.
- R6: T (01101) followed by R (00111) ends the packet. rx_dv is low in the cycles that follow both T and R.
- R7: Inside a packet, Halt (00100), any group outside the code set, or any control group other than T gives one nibble with rx_dv=1, rx_er=1 and rxd=0000.
- R8: Outside a packet, Idle (11111) and data groups keep rx_dv and rx_er low. This also holds right after reset, when rxd is 0000.
- R9: A T group followed by anything other than R gives one nibble with rx_dv=1, rx_er=1 and rxd=0000, then returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one code group per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_ok | input | 1 | Frame-lock status from the link receiver |
| code_in | input | 5 | Received 5-bit code group |
| rxd | output | 4 | Decoded nibble to the MAC |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the current nibble |

## Verification
Every decoded result (a nibble, the start-of-frame nibble, an error nibble or the absence of data-valid) belongs to the group sampled at the previous rising edge, so it is due exactly one clock later. The bench drives each group on a falling edge and reads the outputs at the next falling edge, half a cycle after the register has loaded. The one exception is loss of frame lock. It masks rx_dv and rx_er in the same cycle, so that check samples shortly after sync_ok falls, before any clock edge.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int CODE_W = 5;
  localparam int NIB_W  = 4;

  localparam logic [CODE_W-1:0] GRP_IDLE = 5'b11111;
  localparam logic [CODE_W-1:0] GRP_J    = 5'b11000;
  localparam logic [CODE_W-1:0] GRP_K    = 5'b10001;
  localparam logic [CODE_W-1:0] GRP_T    = 5'b01101;
  localparam logic [CODE_W-1:0] GRP_R    = 5'b00111;
  localparam logic [CODE_W-1:0] GRP_H    = 5'b00100;

  localparam logic [NIB_W-1:0] SOF_NIB = 4'b0101;

  typedef enum logic [2:0] {
    SYM_DATA, SYM_IDLE, SYM_J, SYM_K, SYM_T, SYM_R, SYM_HALT, SYM_BAD
  } sym_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_GOT_J, ST_PKT, ST_GOT_T
  } rx_st_e;
endpackage

// File: rtl/mii_sym_decode.sv
module mii_sym_decode
  import mii_rx_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output sym_e              kind,
  output logic [NIB_W-1:0]  nib
);
  always_comb begin
    kind = SYM_DATA;
    nib  = '0;
    unique case (code)
      5'b11110: nib = 4'h0;
      5'b01001: nib = 4'h1;
      5'b10100: nib = 4'h2;
      5'b10101: nib = 4'h3;
      5'b01010: nib = 4'h4;
      5'b01011: nib = 4'h5;
      5'b01110: nib = 4'h6;
      5'b01111: nib = 4'h7;
      5'b10010: nib = 4'h8;
      5'b10011: nib = 4'h9;
      5'b10110: nib = 4'hA;
      5'b10111: nib = 4'hB;
      5'b11010: nib = 4'hC;
      5'b11011: nib = 4'hD;
      5'b11100: nib = 4'hE;
      5'b11101: nib = 4'hF;
      GRP_IDLE: kind = SYM_IDLE;
      GRP_J:    kind = SYM_J;
      GRP_K:    kind = SYM_K;
      GRP_T:    kind = SYM_T;
      GRP_R:    kind = SYM_R;
      GRP_H:    kind = SYM_HALT;
      default:  kind = SYM_BAD;
    endcase
  end
endmodule

// File: rtl/mii_rx_fsm.sv
module mii_rx_fsm
  import mii_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_ok,
  input  sym_e             kind,
  input  logic [NIB_W-1:0] nib,
  output rx_st_e           st_q,
  output logic [NIB_W-1:0] d_q,
  output logic             dv_q,
  output logic             er_q
);
  rx_st_e           st_d;
  logic [NIB_W-1:0] d_d;
  logic             dv_d;
  logic             er_d;
  logic             upd_en;

  // next-state and output decode
  always_comb begin
    st_d = st_q;
    d_d  = '0;
    dv_d = 1'b0;
    er_d = 1'b0;
    if (!sync_ok) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (kind == SYM_J) st_d = ST_GOT_J;
        end
        ST_GOT_J: begin
          if (kind == SYM_K) begin
            st_d = ST_PKT;
            dv_d = 1'b1;
            d_d  = SOF_NIB;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_PKT: begin
          if (kind == SYM_DATA) begin
            dv_d = 1'b1;
            d_d  = nib;
          end else if (kind == SYM_T) begin
            st_d = ST_GOT_T;
          end else begin
            dv_d = 1'b1;
            er_d = 1'b1;
          end
        end
        ST_GOT_T: begin
          st_d = ST_IDLE;
          if (kind != SYM_R) begin
            dv_d = 1'b1;
            er_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      d_q  <= '0;
      dv_q <= 1'b0;
      er_q <= 1'b0;
    end else if (upd_en) begin
      st_q <= st_d;
      d_q  <= d_d;
      dv_q <= dv_d;
      er_q <= er_d;
    end
  end
endmodule

// File: rtl/mii_rx_decoder.sv
module mii_rx_decoder
  import mii_rx_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_ok,
  input  logic [CODE_W-1:0] code_in,
  output logic [NIB_W-1:0]  rxd,
  output logic              rx_dv,
  output logic              rx_er
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q_n;
  sym_e                  kind;
  logic [NIB_W-1:0]      nib;
  rx_st_e                st_q;
  logic [NIB_W-1:0]      d_q;
  logic                  dv_q;
  logic                  er_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[RST_STAGES-1];

  mii_sym_decode dec_i (
    .code (code_in),
    .kind (kind),
    .nib  (nib)
  );

  mii_rx_fsm fsm_i (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .sync_ok (sync_ok),
    .kind    (kind),
    .nib     (nib),
    .st_q    (st_q),
    .d_q     (d_q),
    .dv_q    (dv_q),
    .er_q    (er_q)
  );

  // lock loss masks the interface in the same cycle
  assign rxd   = sync_ok ? d_q : '0;
  assign rx_dv = dv_q & sync_ok;
  assign rx_er = er_q & sync_ok;
endmodule

// File: rtl/mii_rx_decoder_chk.sv
module mii_rx_decoder_chk
  import mii_rx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sync_ok,
  input logic [CODE_W-1:0] code_in,
  input rx_st_e            st_q,
  input logic [NIB_W-1:0]  rxd,
  input logic              rx_dv,
  input logic              rx_er
);
  assert_lock_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> !rx_dv);

  assert_sof_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GOT_J && sync_ok && code_in == GRP_K)
      |=> (!sync_ok || (rx_dv && !rx_er && rxd == SOF_NIB)));

  assert_j_absorbed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && code_in == GRP_J) |=> !rx_dv);

  assert_end_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GOT_T && sync_ok && code_in == GRP_R) |=> !rx_dv);

  assert_halt_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PKT && sync_ok && code_in == GRP_H) |=> (!sync_ok || (rx_dv && rx_er)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |=> !rx_dv);

  assert_err_has_dv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> rx_dv);
endmodule

bind mii_rx_decoder mii_rx_decoder_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .sync_ok (sync_ok),
  .code_in (code_in),
  .st_q    (st_q),
  .rxd     (rxd),
  .rx_dv   (rx_dv),
  .rx_er   (rx_er)
);

// File: tb/mii_rx_decoder_tb.sv
module mii_rx_decoder_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk;
  logic       rst_n;
  logic       sync_ok;
  logic [4:0] code_in;
  logic [3:0] rxd;
  logic       rx_dv;
  logic       rx_er;
  int         checks;
  int         errors;

  localparam logic [4:0] C_IDLE = 5'b11111;
  localparam logic [4:0] C_J    = 5'b11000;
  localparam logic [4:0] C_K    = 5'b10001;
  localparam logic [4:0] C_T    = 5'b01101;
  localparam logic [4:0] C_R    = 5'b00111;
  localparam logic [4:0] C_H    = 5'b00100;

  mii_rx_decoder dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_ok (sync_ok),
    .code_in (code_in),
    .rxd     (rxd),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
      4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
      4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
      4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
      4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
      4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
      4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
      4'hE: enc = 5'b11100; default: enc = 5'b11101;
    endcase
  endfunction

  task automatic chk(input string req, input logic dv, input logic er, input logic [3:0] d);
    checks++;
    if ({rx_dv, rx_er, rxd} !== {dv, er, d}) begin
      errors++;
      $display("FAIL %s: dv/er/d actual %b/%b/%h expected %b/%b/%h",
               req, rx_dv, rx_er, rxd, dv, er, d);
    end
  endtask

  // drive a group on a falling edge, check its result one falling edge later
  task automatic send(input logic [4:0] c, input string req,
                      input logic dv, input logic er, input logic [3:0] d);
    code_in = c;
    @(negedge clk);
    chk(req, dv, er, d);
  endtask

  task automatic t_reset;
    chk("R8 reset", 1'b0, 1'b0, 4'h0);
    send(C_IDLE, "R8 idle", 1'b0, 1'b0, 4'h0);
    send(enc(4'h7), "R8 data outside packet", 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_packet;
    send(C_J, "R4 J absorbed", 1'b0, 1'b0, 4'h0);
    send(C_K, "R3 start nibble", 1'b1, 1'b0, 4'h5);
    for (int i = 0; i < 16; i++)
      send(enc(4'(i)), "R1 data decode", 1'b1, 1'b0, 4'(i));
    send(C_T, "R6 T not forwarded", 1'b0, 1'b0, 4'h0);
    send(C_R, "R6 R not forwarded", 1'b0, 1'b0, 4'h0);
    send(enc(4'h3), "R6 closed after T R", 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_bad_j;
    send(C_J, "R4 J absorbed", 1'b0, 1'b0, 4'h0);
    send(enc(4'h9), "R5 J without K", 1'b0, 1'b0, 4'h0);
    send(C_K, "R5 late K ignored", 1'b0, 1'b0, 4'h0);
    send(enc(4'hA), "R5 still idle", 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_errors;
    send(C_J, "R4 J absorbed", 1'b0, 1'b0, 4'h0);
    send(C_K, "R3 start nibble", 1'b1, 1'b0, 4'h5);
    send(C_H, "R7 halt", 1'b1, 1'b1, 4'h0);
    send(enc(4'hC), "R1 data after error", 1'b1, 1'b0, 4'hC);
    send(5'b00000, "R7 invalid group", 1'b1, 1'b1, 4'h0);
    send(C_IDLE, "R7 idle inside packet", 1'b1, 1'b1, 4'h0);
    send(C_T, "R6 T", 1'b0, 1'b0, 4'h0);
    send(C_R, "R6 R", 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_bad_t;
    send(C_J, "R4 J absorbed", 1'b0, 1'b0, 4'h0);
    send(C_K, "R3 start nibble", 1'b1, 1'b0, 4'h5);
    send(C_T, "R9 T", 1'b0, 1'b0, 4'h0);
    send(enc(4'h2), "R9 T without R", 1'b1, 1'b1, 4'h0);
    send(enc(4'h4), "R9 back to idle", 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_sync_loss;
    send(C_J, "R4 J absorbed", 1'b0, 1'b0, 4'h0);
    send(C_K, "R3 start nibble", 1'b1, 1'b0, 4'h5);
    send(enc(4'h6), "R1 data", 1'b1, 1'b0, 4'h6);
    code_in = enc(4'h1);
    sync_ok = 1'b0;
    #1;
    chk("R2 same-cycle mask", 1'b0, 1'b0, 4'h0);
    @(negedge clk);
    chk("R2 held low", 1'b0, 1'b0, 4'h0);
    sync_ok = 1'b1;
    send(enc(4'h8), "R2 packet abandoned", 1'b0, 1'b0, 4'h0);
    send(C_J, "R2 J after relock", 1'b0, 1'b0, 4'h0);
    send(C_K, "R2 new start", 1'b1, 1'b0, 4'h5);
    send(C_T, "R6 T", 1'b0, 1'b0, 4'h0);
    send(C_R, "R6 R", 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    rst_n   = 1'b0;
    sync_ok = 1'b0;
    code_in = C_IDLE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sync_ok = 1'b1;
    @(negedge clk);
    t_reset();
    t_packet();
    t_bad_j();
    t_errors();
    t_bad_t();
    t_sync_loss();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule